// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the byte address of a memory access from a base register value and an offset, and also produces the value that should be written back into the base register. The offset comes from one of three sources. It can be a 12-bit unsigned immediate, a second register value, or a second register value shifted by a constant amount. The offset is added to or subtracted from the base.

Three indexing modes decide which sum appears where. In the non-updating mode the sum is the access address and nothing is written back. In the pre-indexed mode the sum is both the access address and the written-back base. In the post-indexed mode the access goes to the unmodified base and the sum is written back.

Every accepted request is registered once. The address, the new base and the writeback strobe appear one clock after the request, together with a valid flag. A load/store pipeline stage places the unit between operand read and the memory port.

Top module: `agu_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `wb_en` are 0 after that edge, whatever `in_valid` is.
- R2: A request sampled with `in_valid`=1 at a rising edge appears on the outputs with `out_valid`=1 after that same edge. An edge with `in_valid`=0 leaves `out_valid`=0 and `wb_en`=0.
- R3: With `ofs_src`=0 (or the reserved code 3), the offset is `imm12` zero-extended to 32 bits. `sub`=1 subtracts the offset from `base`, and `sub`=0 adds it.
- R4: With `ofs_src`=1, the offset is `rm` unshifted. `shift_kind` and `shift_amt` have no effect in this case.
- R5: With `ofs_src`=2, the offset is `rm` shifted by `shift_amt`. The `shift_kind` codes are 0 for logical left, 1 for logical right, 2 for arithmetic right and 3 for rotate right. For example, index 3 with a left shift of 2 gives byte offset 12.
- R6: A `shift_amt` of 0 passes `rm` through unchanged for every shift kind.
- R7: With `idx_mode`=0 (or the reserved code 3), `addr` is base±offset, `new_base` equals `base`, and `wb_en`=0.
- R8: With `idx_mode`=1 (pre-indexed), `addr` and `new_base` both equal base±offset, and `wb_en`=1.
- R9: With `idx_mode`=2 (post-indexed), `addr` equals the unmodified `base`, `new_base` equals base±offset, and `wb_en`=1.
- R10: Address arithmetic wraps modulo 2^32 on both overflow and underflow.
- R11: After an edge with `in_valid`=0, `addr` and `new_base` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| base | input | 32 | Base register value |
| rm | input | 32 | Second register value |
| imm12 | input | 12 | Unsigned immediate byte offset |
| ofs_src | input | 2 | Offset source: 0 immediate, 1 register, 2 shifted register |
| sub | input | 1 | 1 subtracts the offset, 0 adds it |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_amt | input | 5 | Shift amount, 0 to 31 |
| idx_mode | input | 2 | 0 no writeback, 1 pre-indexed, 2 post-indexed |
| out_valid | output | 1 | Registered result valid |
| addr | output | 32 | Access address |
| new_base | output | 32 | Value to write back into the base register |
| wb_en | output | 1 | Base writeback strobe |

## Verification
Random requests cover every combination of offset source, direction, shift kind and indexing mode. Because the bases and offsets are random, a swap between the access address and the writeback value shows up in post-indexed mode but not in pre-indexed mode. Directed cases catch other specific faults:
- an index scaled by four exposes a wrong shift direction;
- zero shift amounts for each kind expose a special-cased zero shift;
- a negative register value under arithmetic right shift tells it apart from a logical right shift;
- carry and borrow past 32 bits expose a lost wraparound.

Requests with nonzero shift fields in register mode, reserved mode codes, and idle cycles show that ignored fields stay ignored and that held outputs stay held.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int AGU_XLEN  = 32;
    localparam int AGU_IMM_W = 12;
    localparam int AGU_SAMT_W = $clog2(AGU_XLEN);

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        OFS_IMM   = 2'd0,
        OFS_REG   = 2'd1,
        OFS_SHREG = 2'd2,
        OFS_RSV   = 2'd3
    } ofs_src_e;

    typedef enum logic [1:0] {
        IX_NONE = 2'd0,
        IX_PRE  = 2'd1,
        IX_POST = 2'd2,
        IX_RSV  = 2'd3
    } idx_mode_e;

    typedef struct packed {
        logic [AGU_XLEN-1:0] addr;
        logic [AGU_XLEN-1:0] new_base;
        logic                wb;
    } agu_result_t;

    function automatic logic [AGU_XLEN-1:0] agu_zext_imm(input logic [AGU_IMM_W-1:0] imm);
        return {{(AGU_XLEN-AGU_IMM_W){1'b0}}, imm};
    endfunction
endpackage

// File: rtl/agu_shifter.sv
module agu_shifter
    import agu_pkg::*;
#(
    parameter int W = AGU_XLEN,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  shift_kind_e   kind,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  res
);
    logic [SW:0] back_amt;

    always_comb begin
        back_amt = (SW+1)'(W) - {1'b0, amt};
        unique case (kind)
            SH_LSL:  res = val << amt;
            SH_LSR:  res = val >> amt;
            SH_ASR:  res = $unsigned($signed(val) >>> amt);
            SH_ROR:  res = (val >> amt) | (val << back_amt);
            default: res = val;
        endcase
    end
endmodule

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
    import agu_pkg::*;
#(
    parameter int W = AGU_XLEN
) (
    input  ofs_src_e             src,
    input  logic [AGU_IMM_W-1:0] imm,
    input  logic [W-1:0]         rm,
    input  logic [W-1:0]         rm_shifted,
    output logic [W-1:0]         offset
);
    always_comb begin
        unique case (src)
            OFS_REG:   offset = rm;
            OFS_SHREG: offset = rm_shifted;
            default:   offset = agu_zext_imm(imm);
        endcase
    end
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage
    import agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  agu_result_t d,
    output logic        q_valid,
    output agu_result_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid    <= 1'b0;
            q.wb       <= 1'b0;
            q.addr     <= '0;
            q.new_base <= '0;
        end else begin
            q_valid <= in_valid;
            q.wb    <= in_valid & d.wb;
            if (in_valid) begin
                q.addr     <= d.addr;
                q.new_base <= d.new_base;
            end
        end
    end

    // R2: writeback strobe never without valid
    a_r2_wb_needs_valid: assert property (@(posedge clk) disable iff (rst)
        q.wb |-> q_valid);

    // R11: idle cycle holds data
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(q.addr) && $stable(q.new_base)));

    // R1: reset clears valid
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!q_valid && !q.wb));
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen
    import agu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [AGU_XLEN-1:0]   base,
    input  logic [AGU_XLEN-1:0]   rm,
    input  logic [AGU_IMM_W-1:0]  imm12,
    input  logic [1:0]            ofs_src,
    input  logic                  sub,
    input  logic [1:0]            shift_kind,
    input  logic [AGU_SAMT_W-1:0] shift_amt,
    input  logic [1:0]            idx_mode,
    output logic                  out_valid,
    output logic [AGU_XLEN-1:0]   addr,
    output logic [AGU_XLEN-1:0]   new_base,
    output logic                  wb_en
);
    logic [AGU_XLEN-1:0] rm_shifted;
    logic [AGU_XLEN-1:0] offset;
    logic [AGU_XLEN-1:0] sum;
    agu_result_t         comb_res;
    agu_result_t         reg_res;

    agu_shifter #(.W(AGU_XLEN)) u_shift (
        .val  (rm),
        .kind (shift_kind_e'(shift_kind)),
        .amt  (shift_amt),
        .res  (rm_shifted)
    );

    agu_offset_sel #(.W(AGU_XLEN)) u_ofs (
        .src        (ofs_src_e'(ofs_src)),
        .imm        (imm12),
        .rm         (rm),
        .rm_shifted (rm_shifted),
        .offset     (offset)
    );

    always_comb begin
        sum = sub ? (base - offset) : (base + offset);
        unique case (idx_mode_e'(idx_mode))
            IX_PRE: begin
                comb_res.addr     = sum;
                comb_res.new_base = sum;
                comb_res.wb       = 1'b1;
            end
            IX_POST: begin
                comb_res.addr     = base;
                comb_res.new_base = sum;
                comb_res.wb       = 1'b1;
            end
            default: begin
                comb_res.addr     = sum;
                comb_res.new_base = base;
                comb_res.wb       = 1'b0;
            end
        endcase
    end

    agu_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d        (comb_res),
        .q_valid  (out_valid),
        .q        (reg_res)
    );

    assign addr     = reg_res.addr;
    assign new_base = reg_res.new_base;
    assign wb_en    = reg_res.wb;

    // R6: zero shift amount passes the register through
    a_r6_zero_shift: assert property (@(posedge clk) disable iff (rst)
        (shift_amt == '0) |-> (rm_shifted == rm));

    // R2: one-cycle latency of valid
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9: post-indexed access uses the unmodified base
    a_r9_post_addr: assert property (@(posedge clk) disable iff (rst)
        (in_valid && idx_mode == 2'd2) |=> (addr == $past(base) && wb_en));

    // R8: pre-indexed access writes back the access address
    a_r8_pre_same: assert property (@(posedge clk) disable iff (rst)
        (in_valid && idx_mode == 2'd1) |=> (addr == new_base && wb_en));

    // R7: non-updating keeps base and raises no strobe
    a_r7_none_keeps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (idx_mode == 2'd0 || idx_mode == 2'd3))
        |=> (!wb_en && new_base == $past(base)));
endmodule

// File: tb/agu_addr_gen_test.sv
module agu_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] base, rm;
    logic [11:0] imm12;
    logic [1:0]  ofs_src, shift_kind, idx_mode;
    logic        sub;
    logic [4:0]  shift_amt;
    logic        out_valid, wb_en;
    logic [31:0] addr, new_base;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    agu_addr_gen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .base(base), .rm(rm),
        .imm12(imm12), .ofs_src(ofs_src), .sub(sub), .shift_kind(shift_kind),
        .shift_amt(shift_amt), .idx_mode(idx_mode), .out_valid(out_valid),
        .addr(addr), .new_base(new_base), .wb_en(wb_en)
    );

    function automatic logic [31:0] ref_shift(input logic [31:0] v, input logic [1:0] k,
                                              input logic [4:0] n);
        logic [63:0] dbl;
        logic [31:0] r;
        dbl = {v, v};
        case (k)
            2'd0: r = v << n;
            2'd1: r = v >> n;
            2'd2: begin
                r = v;
                for (int i = 0; i < 32; i++) if (i < int'(n)) r = {v[31], r[31:1]};
            end
            default: r = dbl[n +: 32];
        endcase
        return r;
    endfunction

    function automatic logic [31:0] ref_offset(input logic [1:0] src, input logic [11:0] im,
                                               input logic [31:0] r, input logic [1:0] k,
                                               input logic [4:0] n);
        if (src == 2'd1) return r;
        if (src == 2'd2) return ref_shift(r, k, n);
        return {20'd0, im};
    endfunction

    task automatic check(input string tag, input logic v, input logic [31:0] ea,
                         input logic [31:0] eb, input logic ew);
        n_tests++;
        if (out_valid !== v || addr !== ea || new_base !== eb || wb_en !== ew) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b addr=%h new_base=%h wb=%0b, expected valid=%0b addr=%h new_base=%h wb=%0b",
                     tag, out_valid, addr, new_base, wb_en, v, ea, eb, ew);
        end
    endtask

    task automatic run(input string tag, input logic [31:0] b, input logic [31:0] r,
                       input logic [11:0] im, input logic [1:0] src, input logic s,
                       input logic [1:0] k, input logic [4:0] n, input logic [1:0] m);
        logic [31:0] ofs, sm, ea, eb;
        logic        ew;
        ofs = ref_offset(src, im, r, k, n);
        sm  = s ? b - ofs : b + ofs;
        if (m == 2'd1)      begin ea = sm; eb = sm; ew = 1'b1; end
        else if (m == 2'd2) begin ea = b;  eb = sm; ew = 1'b1; end
        else                begin ea = sm; eb = b;  ew = 1'b0; end
        @(negedge clk);
        in_valid = 1'b1; base = b; rm = r; imm12 = im; ofs_src = src; sub = s;
        shift_kind = k; shift_amt = n; idx_mode = m;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, 1'b1, ea, eb, ew);
    endtask

    initial begin
        logic [31:0] la, lb;
        void'($urandom(32'h5eed_0a61));
        rst = 1'b1; in_valid = 1'b1; base = 32'h1234; rm = 0; imm12 = 12'h10;
        ofs_src = 0; sub = 0; shift_kind = 0; shift_amt = 0; idx_mode = 2'd1;
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 32'h0, 32'h0, 1'b0);
        rst = 1'b0; in_valid = 1'b0;

        // directed corners
        run("R3 imm add", 32'h0000_1000, 32'h0, 12'hFFF, 2'd0, 1'b0, 2'd0, 5'd0, 2'd0);
        run("R3 imm sub", 32'h0000_1000, 32'h0, 12'h004, 2'd0, 1'b1, 2'd0, 5'd0, 2'd0);
        run("R3 rsv src as imm", 32'h100, 32'hDEAD, 12'h020, 2'd3, 1'b0, 2'd1, 5'd3, 2'd0);
        run("R4 reg ignores shift", 32'h100, 32'h40, 12'h7, 2'd1, 1'b0, 2'd0, 5'd4, 2'd0);
        run("R5 index scale", 32'h1000, 32'd3, 12'h0, 2'd2, 1'b0, 2'd0, 5'd2, 2'd0);
        run("R5 asr negative", 32'h0, 32'h8000_0000, 12'h0, 2'd2, 1'b0, 2'd2, 5'd4, 2'd0);
        run("R5 lsr", 32'h0, 32'h8000_0000, 12'h0, 2'd2, 1'b0, 2'd1, 5'd4, 2'd0);
        run("R5 ror", 32'h0, 32'h0000_00AB, 12'h0, 2'd2, 1'b0, 2'd3, 5'd8, 2'd0);
        for (int k = 0; k < 4; k++)
            run("R6 zero shift", 32'h10, 32'hF00D_BEEF, 12'h0, 2'd2, 1'b0, 2'(k), 5'd0, 2'd0);
        run("R7 rsv mode", 32'h200, 32'h0, 12'h8, 2'd0, 1'b0, 2'd0, 5'd0, 2'd3);
        run("R8 pre", 32'h200, 32'h0, 12'h4, 2'd0, 1'b0, 2'd0, 5'd0, 2'd1);
        run("R9 post", 32'h200, 32'h0, 12'h4, 2'd0, 1'b0, 2'd0, 5'd0, 2'd2);
        run("R10 overflow", 32'hFFFF_FFFC, 32'h0, 12'h8, 2'd0, 1'b0, 2'd0, 5'd0, 2'd1);
        run("R10 underflow", 32'h4, 32'h8, 12'h0, 2'd1, 1'b1, 2'd0, 5'd0, 2'd2);

        // idle: valid drops, data held
        la = addr; lb = new_base;
        @(negedge clk);
        check("R2 R11 idle", 1'b0, la, lb, 1'b0);

        // random sweep over all combinations
        for (int i = 0; i < 400; i++) begin
            logic [1:0] src, m;
            src = 2'($urandom % 3);
            m   = 2'($urandom % 4);
            run(m == 2'd1 ? "R8 rand" : (m == 2'd2 ? "R9 rand" : "R7 rand"),
                $urandom, $urandom, 12'($urandom), src, 1'($urandom),
                2'($urandom), 5'($urandom), m);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule